// File: doc/BRIEF.md
# Multithreaded In-Order Retire Controller

This block chooses, each cycle, one hardware thread and retires completed instructions from the oldest end of that thread's reorder buffer, up to `COMMIT_WIDTH` per cycle. For each thread it sees only a window of the oldest `COMMIT_WIDTH` entries. Each entry shows whether it is valid, whether it has completed, whether it must run non-speculatively, and its sequence number. Slot 0 of a window is the oldest entry.

An instruction that must not run speculatively is held until it becomes the oldest entry of its thread. The controller then broadcasts that thread and sequence number so that earlier stages may issue it, and it retires the instruction once it reports completed. Three counters record the following: cycles lost to such waits, cycles in which retire bandwidth ran out, and ready instructions that other threads could not retire in those cycles. The thread is chosen by one of three policies, picked by a 2-bit input.

Top module: `mt_retire_ctrl`

## Requirements
- R1: After reset all three counters read zero. The round-robin pointer starts at thread 0, and no instruction is held as released.
- R2: Retirement covers the longest run of entries starting at slot 0 that are valid and completed, up to `COMMIT_WIDTH`. `ret_strobe[k]` high means slot k retires this cycle, and the strobes are always contiguous from bit 0. An incomplete entry stops the run, and no later slot retires past it.
- R3: All strobes in a cycle belong to the thread named by `ret_tid`. A thread whose `thr_active` bit is low is never chosen. If no active thread has a retirable slot 0, all strobes are low.
- R4: A non-speculative entry can retire only from slot 0. When one sits at slot 1 or later, the run stops just before it.
- R5: When an active thread's slot 0 is a valid non-speculative entry that has not yet been released, the same cycle shows `ns_rel_valid` with that thread in `ns_rel_tid` and its sequence number in `ns_rel_seq`. At most one release happens per cycle, and the lowest-numbered waiting thread wins. The same instruction is never released twice, so a losing thread is released in a later cycle.
- R6: A non-speculative entry retires only after its release and once it reports completed. It retires alone: the strobe pattern is 001.
- R7: Policy 0 (greedy) picks the active thread with the most retirable entries. A tie goes to the lower thread number.
- R8: Policy 1 (round-robin) searches upward from a pointer, wrapping around. After any retirement the pointer moves to the thread after the one that retired.
- R9: Policy 2 and policy 3 (oldest-ready) pick the eligible thread whose slot-0 sequence number is smallest, comparing as unsigned values.
- R10: `nsq_stall_cnt` increments in every cycle that retires nothing while some active thread has a valid non-speculative slot 0 that is not retirable.
- R11: In every cycle that retires exactly `COMMIT_WIDTH` entries, `bw_hit_cnt` increments by one. In the same cycle, `bw_lost_cnt` grows by the number of retirable entries held by the active threads that were not chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0 greedy, 1 round-robin, 2/3 oldest-ready |
| thr_active | input | NUM_THREADS | Thread enable mask |
| hd_valid | input | NUM_THREADS*COMMIT_WIDTH | Entry valid, bit t*COMMIT_WIDTH+k is slot k of thread t |
| hd_done | input | NUM_THREADS*COMMIT_WIDTH | Entry completed, same layout |
| hd_nonspec | input | NUM_THREADS*COMMIT_WIDTH | Entry non-speculative, same layout |
| hd_seq | input | NUM_THREADS*COMMIT_WIDTH*SEQ_W | Sequence numbers, field (t*COMMIT_WIDTH+k) |
| ret_strobe | output | COMMIT_WIDTH | Per-slot retire strobes |
| ret_tid | output | TID_W | Thread retiring this cycle |
| ns_rel_valid | output | 1 | Non-speculative release broadcast |
| ns_rel_tid | output | TID_W | Thread of released instruction |
| ns_rel_seq | output | SEQ_W | Sequence number of released instruction |
| nsq_stall_cnt | output | CNT_W | Non-speculative wait stall cycles |
| bw_hit_cnt | output | CNT_W | Cycles at full retire bandwidth |
| bw_lost_cnt | output | CNT_W | Ready entries left behind at full bandwidth |

## Verification
The bench probes gaps inside the window. A design that skipped an incomplete entry would show strobes such as 101, breaking in-order retirement. It also presents two threads whose non-speculative heads wait at the same time. A design without the one-per-cycle limit would release both together, and one that forgot earlier releases would broadcast the same instruction again. A non-speculative entry that is already completed but not yet released must stay put, and one behind slot 0 must cut the run short. The policy tests use ties, pointer wrap and unsigned age comparison, where a wrong tiebreak or a pointer that does not advance picks the wrong thread.

// File: rtl/mt_retire_ctrl.sv
module mt_retire_ctrl #(
  parameter int NUM_THREADS  = 2,
  parameter int COMMIT_WIDTH = 3,
  parameter int SEQ_W        = 16,
  parameter int CNT_W        = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW_W  = $clog2(COMMIT_WIDTH + 1),
  localparam int SLOTS = NUM_THREADS * COMMIT_WIDTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy,
  input  logic [NUM_THREADS-1:0] thr_active,
  input  logic [SLOTS-1:0]       hd_valid,
  input  logic [SLOTS-1:0]       hd_done,
  input  logic [SLOTS-1:0]       hd_nonspec,
  input  logic [SLOTS*SEQ_W-1:0] hd_seq,
  output logic [COMMIT_WIDTH-1:0] ret_strobe,
  output logic [TID_W-1:0]       ret_tid,
  output logic                   ns_rel_valid,
  output logic [TID_W-1:0]       ns_rel_tid,
  output logic [SEQ_W-1:0]       ns_rel_seq,
  output logic [CNT_W-1:0]       nsq_stall_cnt,
  output logic [CNT_W-1:0]       bw_hit_cnt,
  output logic [CNT_W-1:0]       bw_lost_cnt
);

  logic [NUM_THREADS-1:0] rel_pend;
  logic [SEQ_W-1:0]       rel_seq [NUM_THREADS];
  logic [TID_W-1:0]       rr_ptr;

  logic [SEQ_W-1:0]       head_seq [NUM_THREADS];
  logic [NUM_THREADS-1:0] head_ns, released, waiting, rel_cand;
  logic [CW_W-1:0]        elig_cnt [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam int B = t * COMMIT_WIDTH;
    assign head_seq[t] = hd_seq[B*SEQ_W +: SEQ_W];
    assign head_ns[t]  = thr_active[t] && hd_valid[B] && hd_nonspec[B];
    assign released[t] = rel_pend[t] && (rel_seq[t] == head_seq[t]);
    assign waiting[t]  = head_ns[t] && !(hd_done[B] && released[t]);
    assign rel_cand[t] = head_ns[t] && !released[t];

    always_comb begin
      logic stop;
      logic ok;
      stop = !thr_active[t];
      elig_cnt[t] = '0;
      for (int k = 0; k < COMMIT_WIDTH; k++) begin
        ok = hd_valid[B+k] && hd_done[B+k] &&
             (!hd_nonspec[B+k] || (k == 0 && released[t]));
        if (!stop && ok) begin
          elig_cnt[t] = elig_cnt[t] + 1'b1;
          if (hd_nonspec[B+k]) stop = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

  logic             sel_found;
  logic [TID_W-1:0] sel;
  logic [CW_W-1:0]  ret_n;

  always_comb begin
    logic [CW_W-1:0]  best_cnt;
    logic [SEQ_W-1:0] best_seq;
    int tt;
    sel_found = 1'b0;
    sel       = '0;
    best_cnt  = '0;
    best_seq  = '0;
    case (policy)
      2'd0: begin
        for (int t = 0; t < NUM_THREADS; t++)
          if (elig_cnt[t] > best_cnt) begin
            best_cnt  = elig_cnt[t];
            sel       = TID_W'(t);
            sel_found = 1'b1;
          end
      end
      2'd1: begin
        for (int i = 0; i < NUM_THREADS; i++) begin
          tt = (int'(rr_ptr) + i) % NUM_THREADS;
          if (!sel_found && elig_cnt[tt] != '0) begin
            sel       = TID_W'(tt);
            sel_found = 1'b1;
          end
        end
      end
      default: begin
        for (int t = 0; t < NUM_THREADS; t++)
          if (elig_cnt[t] != '0 && (!sel_found || head_seq[t] < best_seq)) begin
            best_seq  = head_seq[t];
            sel       = TID_W'(t);
            sel_found = 1'b1;
          end
      end
    endcase
  end

  assign ret_n   = sel_found ? elig_cnt[sel] : '0;
  assign ret_tid = sel;

  for (genvar k = 0; k < COMMIT_WIDTH; k++) begin : g_strobe
    assign ret_strobe[k] = (ret_n > CW_W'(k));
  end

  always_comb begin
    ns_rel_valid = 1'b0;
    ns_rel_tid   = '0;
    ns_rel_seq   = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--)
      if (rel_cand[t]) begin
        ns_rel_valid = 1'b1;
        ns_rel_tid   = TID_W'(t);
        ns_rel_seq   = head_seq[t];
      end
  end

  logic [CNT_W-1:0] lost_add;
  always_comb begin
    lost_add = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (TID_W'(t) != sel) lost_add = lost_add + CNT_W'(elig_cnt[t]);
  end

  wire full_bw = (ret_n == CW_W'(COMMIT_WIDTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_pend      <= '0;
      rr_ptr        <= '0;
      nsq_stall_cnt <= '0;
      bw_hit_cnt    <= '0;
      bw_lost_cnt   <= '0;
      for (int t = 0; t < NUM_THREADS; t++) rel_seq[t] <= '0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (ns_rel_valid && ns_rel_tid == TID_W'(t)) begin
          rel_pend[t] <= 1'b1;
          rel_seq[t]  <= ns_rel_seq;
        end else if (!head_ns[t] || (ret_n != '0 && sel == TID_W'(t))) begin
          rel_pend[t] <= 1'b0;
        end
      end
      if (sel_found)
        rr_ptr <= (int'(sel) == NUM_THREADS - 1) ? '0 : sel + 1'b1;
      if (ret_n == '0 && |waiting)
        nsq_stall_cnt <= nsq_stall_cnt + 1'b1;
      if (full_bw) begin
        bw_hit_cnt  <= bw_hit_cnt + 1'b1;
        bw_lost_cnt <= bw_lost_cnt + lost_add;
      end
    end
  end

endmodule

// File: rtl/mt_retire_ctrl_chk.sv
module mt_retire_ctrl_chk #(
  parameter int NUM_THREADS  = 2,
  parameter int COMMIT_WIDTH = 3,
  parameter int SEQ_W        = 16,
  parameter int CNT_W        = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOTS = NUM_THREADS * COMMIT_WIDTH
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_THREADS-1:0]  thr_active,
  input logic [SLOTS-1:0]        hd_valid,
  input logic [SLOTS-1:0]        hd_nonspec,
  input logic [SLOTS*SEQ_W-1:0]  hd_seq,
  input logic [COMMIT_WIDTH-1:0] ret_strobe,
  input logic [TID_W-1:0]        ret_tid,
  input logic                    ns_rel_valid,
  input logic [TID_W-1:0]        ns_rel_tid,
  input logic [SEQ_W-1:0]        ns_rel_seq,
  input logic [CNT_W-1:0]        nsq_stall_cnt,
  input logic [CNT_W-1:0]        bw_hit_cnt
);

  p_contig_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_strobe & (ret_strobe + 1'b1)) == '0));

  p_active_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe != '0) |-> thr_active[ret_tid]);

  p_release_at_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ns_rel_valid |-> (hd_valid[int'(ns_rel_tid)*COMMIT_WIDTH] &&
                      hd_nonspec[int'(ns_rel_tid)*COMMIT_WIDTH] &&
                      hd_seq[int'(ns_rel_tid)*COMMIT_WIDTH*SEQ_W +: SEQ_W] == ns_rel_seq));

  p_release_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ns_rel_valid |=> !(ns_rel_valid && ns_rel_tid == $past(ns_rel_tid) &&
                       ns_rel_seq == $past(ns_rel_seq)));

  p_nonspec_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe[0] && hd_nonspec[int'(ret_tid)*COMMIT_WIDTH]) |-> (ret_strobe == 1));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe != '0) |=> $stable(nsq_stall_cnt));

  p_bw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe != '1) |=> $stable(bw_hit_cnt));

endmodule

bind mt_retire_ctrl mt_retire_ctrl_chk #(
  .NUM_THREADS(NUM_THREADS), .COMMIT_WIDTH(COMMIT_WIDTH),
  .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/mt_retire_ctrl_bench.sv
module mt_retire_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, CW = 3, SW = 16, CNW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic [NT-1:0] thr_active = '0;
  logic [NT*CW-1:0] hd_valid = '0, hd_done = '0, hd_nonspec = '0;
  logic [NT*CW*SW-1:0] hd_seq = '0;
  logic [CW-1:0] ret_strobe;
  logic [0:0] ret_tid, ns_rel_tid;
  logic ns_rel_valid;
  logic [SW-1:0] ns_rel_seq;
  logic [CNW-1:0] nsq_stall_cnt, bw_hit_cnt, bw_lost_cnt;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_retire_ctrl u_mt_retire_ctrl (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
    .hd_valid(hd_valid), .hd_done(hd_done), .hd_nonspec(hd_nonspec), .hd_seq(hd_seq),
    .ret_strobe(ret_strobe), .ret_tid(ret_tid), .ns_rel_valid(ns_rel_valid),
    .ns_rel_tid(ns_rel_tid), .ns_rel_seq(ns_rel_seq), .nsq_stall_cnt(nsq_stall_cnt),
    .bw_hit_cnt(bw_hit_cnt), .bw_lost_cnt(bw_lost_cnt));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    hd_valid = '0; hd_done = '0; hd_nonspec = '0; hd_seq = '0;
  endtask

  task automatic put(int t, int k, bit d, bit ns, int sq);
    hd_valid[t*CW+k] = 1'b1;
    hd_done[t*CW+k] = d;
    hd_nonspec[t*CW+k] = ns;
    hd_seq[(t*CW+k)*SW +: SW] = SW'(sq);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clear_all(); thr_active = '0; policy = 2'd0;
    step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    check("R1 stall cnt", int'(nsq_stall_cnt), 0);
    check("R1 bw hit", int'(bw_hit_cnt), 0);
    check("R1 bw lost", int'(bw_lost_cnt), 0);
    check("R3 no strobes", int'(ret_strobe), 0);
  endtask

  task automatic t_window();
    do_reset(); thr_active = 2'b01;
    put(0,0,1,0,1); put(0,1,1,0,2); put(0,2,0,0,3); #1;
    check("R2 stop at incomplete", int'(ret_strobe), 3'b011);
    clear_all(); put(0,0,1,0,1); put(0,1,0,0,2); put(0,2,1,0,3); #1;
    check("R2 no skip past gap", int'(ret_strobe), 3'b001);
    clear_all(); put(0,0,1,0,1); put(0,1,1,0,2); put(0,2,1,0,3); #1;
    check("R2 full window", int'(ret_strobe), 3'b111);
    clear_all(); put(0,0,0,0,1); put(0,1,1,0,2); #1;
    check("R3 head incomplete none", int'(ret_strobe), 0);
  endtask

  task automatic t_inactive();
    do_reset(); thr_active = 2'b01;
    put(1,0,1,0,7); put(1,1,1,0,8); #1;
    check("R3 inactive ignored", int'(ret_strobe), 0);
    thr_active = 2'b11; #1;
    check("R3 active strobes", int'(ret_strobe), 3'b011);
    check("R3 tid", int'(ret_tid), 1);
  endtask

  task automatic t_greedy();
    do_reset(); thr_active = 2'b11; policy = 2'd0;
    put(0,0,1,0,1); put(1,0,1,0,9); put(1,1,1,0,10); #1;
    check("R7 most eligible tid", int'(ret_tid), 1);
    check("R7 strobes", int'(ret_strobe), 3'b011);
    put(0,1,1,0,2); #1;
    check("R7 tie low index", int'(ret_tid), 0);
  endtask

  task automatic t_rr();
    do_reset(); thr_active = 2'b11; policy = 2'd1;
    put(0,0,1,0,1); put(1,0,1,0,2); #1;
    check("R8 first pick", int'(ret_tid), 0);
    step();
    check("R8 rotate", int'(ret_tid), 1);
    step();
    check("R8 wrap", int'(ret_tid), 0);
    clear_all(); put(1,0,1,0,4); step();
    check("R8 skip ineligible", int'(ret_tid), 1);
  endtask

  task automatic t_oldest();
    do_reset(); thr_active = 2'b11; policy = 2'd2;
    put(0,0,1,0,50); put(0,1,1,0,51); put(1,0,1,0,20); #1;
    check("R9 smaller seq", int'(ret_tid), 1);
    check("R9 strobes", int'(ret_strobe), 3'b001);
    policy = 2'd3; put(0,0,1,0,10); #1;
    check("R9 policy3", int'(ret_tid), 0);
    put(1,0,1,0,16'hF000); put(0,0,1,0,16'h0FFF); #1;
    check("R9 unsigned", int'(ret_tid), 0);
  endtask

  task automatic t_nonspec();
    do_reset(); thr_active = 2'b11; policy = 2'd0;
    put(0,0,0,1,100); put(0,1,1,0,101); put(1,0,0,1,200); #1;
    check("R5 rel valid", int'(ns_rel_valid), 1);
    check("R5 rel tid low", int'(ns_rel_tid), 0);
    check("R5 rel seq", int'(ns_rel_seq), 100);
    check("R6 held", int'(ret_strobe), 0);
    step();
    check("R5 second thread", int'(ns_rel_tid), 1);
    check("R5 second seq", int'(ns_rel_seq), 200);
    step();
    check("R5 no repeat", int'(ns_rel_valid), 0);
    check("R6 not done held", int'(ret_strobe), 0);
    step();
    check("R10 stall count", int'(nsq_stall_cnt), 3);
    put(0,0,1,1,100); #1;
    check("R6 retires alone", int'(ret_strobe), 3'b001);
    check("R6 tid", int'(ret_tid), 0);
    step();
    check("R10 no inc on retire", int'(nsq_stall_cnt), 3);
  endtask

  task automatic t_nonspec_unreleased();
    do_reset(); thr_active = 2'b01;
    put(0,0,1,1,5); #1;
    check("R6 done but unreleased", int'(ret_strobe), 0);
    step();
    check("R6 after release", int'(ret_strobe), 3'b001);
    clear_all(); put(0,0,1,0,6); put(0,1,1,1,7); put(0,2,1,0,8); #1;
    check("R4 nonspec past head", int'(ret_strobe), 3'b001);
  endtask

  task automatic t_bw();
    do_reset(); thr_active = 2'b11; policy = 2'd0;
    put(0,0,1,0,1); put(0,1,1,0,2); put(0,2,1,0,3); put(1,0,1,0,4); put(1,1,1,0,5); #1;
    check("R11 full strobes", int'(ret_strobe), 3'b111);
    step();
    check("R11 hit", int'(bw_hit_cnt), 1);
    check("R11 lost", int'(bw_lost_cnt), 2);
    clear_all(); put(0,0,1,0,6); put(0,1,1,0,7); step();
    check("R11 no hit", int'(bw_hit_cnt), 1);
    check("R11 lost held", int'(bw_lost_cnt), 2);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_window(); t_inactive(); t_greedy(); t_rr();
        t_oldest(); t_nonspec(); t_nonspec_unreleased(); t_bw();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule